// File: doc/BRIEF.md
# Eight-Line Fixed-Priority Interrupt Controller

This block collects eight interrupt request lines from peripherals and offers one of them at a time to a processor. A rising edge on a request line marks that line pending. The controller raises a single interrupt output when a pending line is enabled and outranks every line already being serviced. The processor answers with an acknowledge pulse. The controller then moves the winning line from pending to in service and presents an 8-bit vector that identifies the line.

Software reaches the block through a byte-wide I/O port pair. One port holds the per-line enable mask and can be read back. The other port accepts commands, and the only command decoded is the end-of-interrupt code. That code retires the highest-priority line in service, which lets requests of the same or lower rank through again. Priority is fixed: line 0 ranks highest and line 7 lowest.

Top module: `picIntCtrl`

## Requirements
- R1: After reset, intReq is 0, intVector is 00H, no line is pending or in service, and the mask register reads back FFH (all lines disabled).
- R2: A 0-to-1 transition on irqLines[n] sets pending bit n, whatever the mask. A line held high does not set pending again after it is acknowledged. It must drop and rise again.
- R3: A write to I/O address 0021H loads the mask register, and a read of 0021H returns it. Mask bit n at 1 disables line n and bit n at 0 enables it, so writing FEH leaves only line 0 able to raise intReq.
- R4: When several enabled lines are pending, an acknowledge grants the lowest-numbered one. One cycle after the acknowledge edge, intVector equals 08H plus that line number (08H for line 0, 0FH for line 7).
- R5: intReq is 1 exactly when some pending, enabled line has a lower number than every line in service.
- R6: An acknowledge while intReq is 1 clears the granted line's pending bit and sets its in-service bit in the same clock edge.
- R7: Writing 20H to I/O address 0020H clears the lowest-numbered in-service bit. Any other value written to 0020H changes nothing.
- R8: While line k is in service, a pending line numbered k or higher does not raise intReq, and a pending line numbered below k does.
- R9: An acknowledge while intReq is 0 changes neither intVector nor any pending or in-service state.
- R10: A write to any address other than 0020H and 0021H has no effect, and reads from such addresses, or with ioRdEn low, return 00H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLines | input | 8 | Interrupt request lines, bit n is line n |
| ioAddr | input | 16 | I/O port address |
| ioWrEn | input | 1 | Write strobe, one cycle per write |
| ioWrData | input | 8 | Write data |
| ioRdEn | input | 1 | Read enable |
| ioRdData | output | 8 | Read data, combinational |
| intAck | input | 1 | Interrupt acknowledge from the processor, one-cycle pulse |
| intReq | output | 1 | Interrupt request to the processor |
| intVector | output | 8 | Vector of the last granted line |

## Verification
The hardest situation to reach from the ports is a nested service. Two lines must be in service at once while a third, lower-ranked line waits pending. Each end-of-interrupt must then retire the correct one of the two. The stimulus gets there in three steps. It acknowledges a mid-priority line and leaves it unretired. It then raises a lower-ranked line, which must stay silent, and a higher-ranked line, which must preempt. Finally it issues a non-matching command value and then two end-of-interrupt commands. It watches intReq stay low until the last retirement frees the waiting line.

// File: rtl/picPkg.sv
package picPkg;
  typedef struct packed {
    logic ackTake;
    logic eoiTake;
    logic maskLoad;
  } picStrobes_t;
endpackage

// File: rtl/picPrioPick.sv
module picPrioPick #(
  parameter int WIDTH = 8,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] reqVec,
  output logic             anyHit,
  output logic [IDX_W-1:0] hitIdx,
  output logic [WIDTH-1:0] hitOneHot
);
  always_comb begin
    anyHit = 1'b0;
    hitIdx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (reqVec[i]) begin
        anyHit = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_onehot
    if (gi == 0) begin : g_top
      assign hitOneHot[gi] = reqVec[gi];
    end else begin : g_rest
      assign hitOneHot[gi] = reqVec[gi] && (reqVec[gi-1:0] == '0);
    end
  end
endmodule

// File: rtl/picControl.sv
module picControl
  import picPkg::*;
#(
  parameter int             ADDR_W    = 16,
  parameter int             DATA_W    = 8,
  parameter int             NUM_LINES = 8,
  parameter logic [15:0]    CMD_ADDR  = 16'h0020,
  parameter logic [15:0]    MASK_ADDR = 16'h0021,
  parameter logic [7:0]     EOI_CODE  = 8'h20
) (
  input  logic [ADDR_W-1:0]    ioAddr,
  input  logic                 ioWrEn,
  input  logic [DATA_W-1:0]    ioWrData,
  input  logic                 ioRdEn,
  input  logic                 intAck,
  input  logic                 reqActive,
  input  logic [NUM_LINES-1:0] maskBits,
  output picStrobes_t          strobes,
  output logic [DATA_W-1:0]    ioRdData
);
  logic hitCmd;
  logic hitMask;

  assign hitCmd  = (ioAddr == ADDR_W'(CMD_ADDR));
  assign hitMask = (ioAddr == ADDR_W'(MASK_ADDR));

  always_comb begin
    strobes          = '0;
    strobes.maskLoad = ioWrEn && hitMask;
    strobes.eoiTake  = ioWrEn && hitCmd && (ioWrData == DATA_W'(EOI_CODE));
    strobes.ackTake  = intAck && reqActive;
  end

  always_comb begin
    ioRdData = '0;
    if (ioRdEn && hitMask) begin
      ioRdData = DATA_W'(maskBits);
    end
  end
endmodule

// File: rtl/picDatapath.sv
module picDatapath
  import picPkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          NUM_LINES = 8,
  parameter logic [7:0]  VEC_BASE  = 8'h08,
  localparam int         IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  picStrobes_t          strobes,
  input  logic [DATA_W-1:0]    ioWrData,
  output logic [NUM_LINES-1:0] maskBits,
  output logic [NUM_LINES-1:0] pendingBits,
  output logic [NUM_LINES-1:0] inServiceBits,
  output logic                 reqActive,
  output logic [DATA_W-1:0]    intVector
);
  logic [NUM_LINES-1:0] irqPrev;
  logic [NUM_LINES-1:0] candBits;
  logic [NUM_LINES-1:0] winOneHot;
  logic [NUM_LINES-1:0] svcOneHot;
  logic [NUM_LINES-1:0] riseBits;
  logic [IDX_W-1:0]     winIdx;
  logic [IDX_W-1:0]     svcIdx;
  logic                 winAny;
  logic                 svcAny;

  assign candBits = pendingBits & ~maskBits;
  assign riseBits = irqLines & ~irqPrev;

  picPrioPick #(.WIDTH(NUM_LINES)) winPick_i (
    .reqVec(candBits), .anyHit(winAny), .hitIdx(winIdx), .hitOneHot(winOneHot)
  );

  picPrioPick #(.WIDTH(NUM_LINES)) svcPick_i (
    .reqVec(inServiceBits), .anyHit(svcAny), .hitIdx(svcIdx), .hitOneHot(svcOneHot)
  );

  assign reqActive = winAny && (!svcAny || (winIdx < svcIdx));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPrev       <= '0;
      pendingBits   <= '0;
      inServiceBits <= '0;
      maskBits      <= '1;
      intVector     <= '0;
    end else begin
      irqPrev     <= irqLines;
      pendingBits <= (pendingBits & ~(strobes.ackTake ? winOneHot : '0)) | riseBits;
      inServiceBits <= (inServiceBits & ~(strobes.eoiTake ? svcOneHot : '0))
                     | (strobes.ackTake ? winOneHot : '0);
      if (strobes.maskLoad) begin
        maskBits <= ioWrData[NUM_LINES-1:0];
      end
      if (strobes.ackTake) begin
        intVector <= DATA_W'(VEC_BASE) + DATA_W'(winIdx);
      end
    end
  end
endmodule

// File: rtl/picIntCtrl.sv
module picIntCtrl
  import picPkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          NUM_LINES = 8,
  parameter logic [15:0] CMD_ADDR  = 16'h0020,
  parameter logic [15:0] MASK_ADDR = 16'h0021,
  parameter logic [7:0]  EOI_CODE  = 8'h20,
  parameter logic [7:0]  VEC_BASE  = 8'h08
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [ADDR_W-1:0]    ioAddr,
  input  logic                 ioWrEn,
  input  logic [DATA_W-1:0]    ioWrData,
  input  logic                 ioRdEn,
  output logic [DATA_W-1:0]    ioRdData,
  input  logic                 intAck,
  output logic                 intReq,
  output logic [DATA_W-1:0]    intVector
);
  picStrobes_t          strobes;
  logic                 reqActive;
  logic [NUM_LINES-1:0] maskBits;
  logic [NUM_LINES-1:0] pendingBits;
  logic [NUM_LINES-1:0] inServiceBits;

  picControl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES),
    .CMD_ADDR(CMD_ADDR), .MASK_ADDR(MASK_ADDR), .EOI_CODE(EOI_CODE)
  ) ctrl_i (
    .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioWrData(ioWrData), .ioRdEn(ioRdEn),
    .intAck(intAck), .reqActive(reqActive), .maskBits(maskBits),
    .strobes(strobes), .ioRdData(ioRdData)
  );

  picDatapath #(
    .DATA_W(DATA_W), .NUM_LINES(NUM_LINES), .VEC_BASE(VEC_BASE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .strobes(strobes),
    .ioWrData(ioWrData), .maskBits(maskBits), .pendingBits(pendingBits),
    .inServiceBits(inServiceBits), .reqActive(reqActive), .intVector(intVector)
  );

  assign intReq = reqActive;
endmodule

// File: rtl/picIntCtrlChecker.sv
module picIntCtrlChecker #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          NUM_LINES = 8,
  parameter logic [15:0] CMD_ADDR  = 16'h0020,
  parameter logic [15:0] MASK_ADDR = 16'h0021,
  parameter logic [7:0]  EOI_CODE  = 8'h20,
  parameter logic [7:0]  VEC_BASE  = 8'h08
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 intAck,
  input logic                 intReq,
  input logic [DATA_W-1:0]    intVector,
  input logic                 ioWrEn,
  input logic [ADDR_W-1:0]    ioAddr,
  input logic [DATA_W-1:0]    ioWrData,
  input logic [NUM_LINES-1:0] pendingBits,
  input logic [NUM_LINES-1:0] maskBits,
  input logic [NUM_LINES-1:0] inServiceBits
);
  logic eoiWrite;
  logic maskWrite;
  assign eoiWrite  = ioWrEn && (ioAddr == ADDR_W'(CMD_ADDR)) && (ioWrData == DATA_W'(EOI_CODE));
  assign maskWrite = ioWrEn && (ioAddr == ADDR_W'(MASK_ADDR));

  a_r5_req_needs_candidate: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> ((pendingBits & ~maskBits) != '0));

  a_r4_vector_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intReq) |=> (intVector >= DATA_W'(VEC_BASE)) &&
                           (intVector < DATA_W'(VEC_BASE) + DATA_W'(NUM_LINES)));

  a_r6_ack_adds_service: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intReq && !eoiWrite) |=>
      ($countones(inServiceBits) == $countones($past(inServiceBits)) + 1));

  a_r9_idle_ack_holds: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !intReq) |=> $stable(intVector));

  a_r7_eoi_retires_one: assert property (@(posedge clk) disable iff (!rstN)
    (eoiWrite && (inServiceBits != '0) && !(intAck && intReq)) |=>
      ($countones(inServiceBits) + 1 == $countones($past(inServiceBits))));

  a_r3_mask_loads: assert property (@(posedge clk) disable iff (!rstN)
    maskWrite |=> (maskBits == $past(ioWrData[NUM_LINES-1:0])));
endmodule

bind picIntCtrl picIntCtrlChecker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES),
  .CMD_ADDR(CMD_ADDR), .MASK_ADDR(MASK_ADDR), .EOI_CODE(EOI_CODE), .VEC_BASE(VEC_BASE)
) chk_i (
  .clk(clk), .rstN(rstN), .intAck(intAck), .intReq(intReq), .intVector(intVector),
  .ioWrEn(ioWrEn), .ioAddr(ioAddr), .ioWrData(ioWrData), .pendingBits(pendingBits),
  .maskBits(maskBits), .inServiceBits(inServiceBits)
);

// File: tb/picIntCtrl_tb_top.sv
module picIntCtrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  irqLines = '0;
  logic [15:0] ioAddr = '0;
  logic        ioWrEn = 1'b0;
  logic [7:0]  ioWrData = '0;
  logic        ioRdEn = 1'b0;
  logic [7:0]  ioRdData;
  logic        intAck = 1'b0;
  logic        intReq;
  logic [7:0]  intVector;

  int checks = 0;
  int failures = 0;
  bit doneFlag = 1'b0;

  typedef struct { logic [7:0] value; string tag; } expItem_t;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  picIntCtrl dut_i (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .ioAddr(ioAddr), .ioWrEn(ioWrEn),
    .ioWrData(ioWrData), .ioRdEn(ioRdEn), .ioRdData(ioRdData), .intAck(intAck),
    .intReq(intReq), .intVector(intVector)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic checkReq(input logic exp, input string tag);
    @(negedge clk);
    check(intReq === exp, tag, {7'b0, intReq}, {7'b0, exp});
  endtask

  task automatic busWrite(input logic [15:0] addr, input logic [7:0] data);
    @(negedge clk);
    ioAddr = addr; ioWrData = data; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic busReadCheck(input logic [15:0] addr, input logic [7:0] exp, input string tag);
    @(negedge clk);
    ioAddr = addr; ioRdEn = 1'b1;
    #1;
    check(ioRdData === exp, tag, ioRdData, exp);
    ioRdEn = 1'b0;
  endtask

  task automatic setLines(input logic [7:0] v);
    @(negedge clk);
    irqLines = v;
    @(negedge clk);
  endtask

  // driver: pushes the expected vector, then pulses acknowledge
  task automatic doAck(input logic [7:0] expVec, input string tag);
    @(negedge clk);
    expQ.push_back('{value: expVec, tag: tag});
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  // monitor: compares the vector after each acknowledge edge
  initial begin
    forever begin
      @(posedge clk);
      if (intAck && expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        @(negedge clk);
        check(intVector === it.value, it.tag, intVector, it.value);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkReq(1'b0, "R1 intReq after reset");
    check(intVector === 8'h00, "R1 vector after reset", intVector, 8'h00);
    busReadCheck(16'h0021, 8'hFF, "R1 mask after reset");

    // R2 pending latches while masked; R3 unmasking releases it
    setLines(8'b0000_1000);
    checkReq(1'b0, "R3 masked line silent");
    busWrite(16'h0021, 8'h00);
    checkReq(1'b1, "R2 pending kept while masked");
    doAck(8'h0B, "R4 vector line3");
    checkReq(1'b0, "R6 acked line leaves pending");
    checkReq(1'b0, "R2 held level does not retrigger");

    // R8 nesting
    setLines(8'b0010_1000);
    checkReq(1'b0, "R8 lower line blocked by service");
    setLines(8'b0010_1010);
    checkReq(1'b1, "R8 higher line preempts");
    doAck(8'h09, "R4 vector line1");
    checkReq(1'b0, "R5 line5 blocked by two in service");

    // R7 end of interrupt
    busWrite(16'h0020, 8'h21);
    checkReq(1'b0, "R7 other command value ignored");
    busWrite(16'h0020, 8'h20);
    checkReq(1'b0, "R7 first EOI retires line1 only");
    busWrite(16'h0020, 8'h20);
    checkReq(1'b1, "R7 second EOI retires line3");
    doAck(8'h0D, "R4 vector line5");
    busWrite(16'h0020, 8'h20);
    checkReq(1'b0, "R7 all retired");

    // R9 idle acknowledge
    doAck(8'h0D, "R9 idle ack keeps vector");
    checkReq(1'b0, "R9 idle ack no request");

    // R10 other addresses
    busWrite(16'h0022, 8'hFF);
    busReadCheck(16'h0021, 8'h00, "R10 stray write leaves mask");
    busReadCheck(16'h0022, 8'h00, "R10 stray read returns zero");
    busWrite(16'h0120, 8'h20);
    busReadCheck(16'h0021, 8'h00, "R10 stray command address");

    // R3 FEH leaves only line 0
    busWrite(16'h0021, 8'hFE);
    busReadCheck(16'h0021, 8'hFE, "R3 mask readback FE");
    setLines(8'h00);
    setLines(8'b0100_0000);
    checkReq(1'b0, "R3 line6 masked by FE");
    setLines(8'b0100_0001);
    checkReq(1'b1, "R3 line0 enabled by FE");
    doAck(8'h08, "R4 vector line0");
    busWrite(16'h0020, 8'h20);
    checkReq(1'b0, "R3 line6 still masked");
    busWrite(16'h0021, 8'h00);
    checkReq(1'b1, "R5 line6 released");
    doAck(8'h0E, "R4 vector line6");
    busWrite(16'h0020, 8'h20);

    // R4 simultaneous requests
    setLines(8'h00);
    setLines(8'b1001_0100);
    doAck(8'h0A, "R4 simultaneous first line2");
    busWrite(16'h0020, 8'h20);
    doAck(8'h0C, "R4 simultaneous second line4");
    busWrite(16'h0020, 8'h20);
    doAck(8'h0F, "R4 simultaneous third line7");
    busWrite(16'h0020, 8'h20);
    checkReq(1'b0, "R5 nothing left pending");

    // R2 new edge after drop
    setLines(8'b1000_0000);
    setLines(8'b1001_0000);
    checkReq(1'b1, "R2 fresh edge sets pending");
    doAck(8'h0C, "R2 vector after fresh edge");
    busWrite(16'h0020, 8'h20);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R4 scoreboard drained", 8'(expQ.size()), 8'h00);

    doneFlag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=00 expected=01");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule